// File: doc/BRIEF.md
# Multi-Format Light-Valve Panel Timing Generator

This block derives all scan timing for a six-input active-matrix light-valve panel from one dot-rate clock. A two-phase horizontal clock advances the panel's column shift register six dots at a time. A horizontal start pulse loads that register once per line. A vertical clock, a vertical start pulse and a gate-enable strobe drive the row scanner. One pin carries the OR of a per-line precharge pulse and a black-frame pulse that is active during vertical blanking. A polarity flag tells the video path to invert on alternate lines.

A three-bit format code selects one of five display formats. Each format has its own active line count and its own count of horizontal clocks per line. The code is registered, and the generator switches to a new code only when the current frame wraps, so no frame is ever cut short. The two scan-direction inputs reach the panel unchanged. The applied format code is driven to the panel's area-select pins.

Top module: `lcd_scan_timing`

## Requirements
- R1: Format codes 0, 1, 2, 3 and 4 select (active lines, horizontal clocks per line) of (624,140), (600,134), (572,128), (480,108) and (400,108) by default. A line lasts (clocks + H_BLANK) horizontal clock periods. A frame lasts (lines + V_BLANK) lines. Codes 5, 6 and 7 select format 0. `mode_o` shows the applied code.
- R2: One horizontal clock period is 2*HCK_HALF dot clocks (six dots with the default of 3). `hck1_o` is high for the first HCK_HALF dots of each period and low for the rest. `hck2_o` is always its complement.
- R3: `hst_o` rises at the middle of the last horizontal clock period of a line and falls at the middle of the first period of the next line. The rise of `hck1_o` that starts a line therefore falls inside the pulse, with HCK_HALF dots of setup and hold.
- R4: `vck_o` toggles at the middle of every line, at horizontal clock index floor(period count / 2). `vst_o` is high for the whole of the frame's last line, so exactly one `vck_o` edge falls inside it.
- R5: `enb_o` is high in every line from horizontal clock index mid + ENB_DLY for ENB_W periods. It is therefore never high in the cycle in which `vck_o` changes.
- R6: `pcg_o` is high in the first PCG_W blanking periods of every line (clock indices starting at the active count). It is also high through every blanking line except the last two, so the black-frame part ends one full line before `vst_o` rises.
- R7: `pol_o` toggles at the start of every line, in the same cycle in which `hck1_o` rises for clock index 0.
- R8: A change of `mode_sel` takes effect only at the first line of the next frame. The running frame keeps its old line and clock counts to the end.
- R9: `dir_h_o` equals `dir_h_in` and `dir_v_o` equals `dir_v_in` at all times, with no clock delay (high means right scan / down scan).
- R10: In reset the generator loads the format from `mode_sel` and holds `hck1_o` low and `hck2_o` high. All other timing outputs and `mode_o` are held low. After release every registered output lags the position counters by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Requested format code |
| dir_h_in | input | 1 | Horizontal scan direction request |
| dir_v_in | input | 1 | Vertical scan direction request |
| hst_o | output | 1 | Horizontal start pulse |
| hck1_o | output | 1 | Horizontal clock, phase 1 |
| hck2_o | output | 1 | Horizontal clock, phase 2 |
| vst_o | output | 1 | Vertical start pulse |
| vck_o | output | 1 | Vertical clock |
| enb_o | output | 1 | Gate-enable strobe |
| pcg_o | output | 1 | Precharge OR black-frame pulse |
| pol_o | output | 1 | Line-inversion polarity flag |
| mode_o | output | 3 | Applied format code for the panel's area-select pins |
| dir_h_o | output | 1 | Horizontal scan direction to panel |
| dir_v_o | output | 1 | Vertical scan direction to panel |

## Verification
The bench sweeps every format code, including the three aliases, over more than a full frame and compares each output in every cycle against positions computed from the cycle count. This catches an off-by-one line or clock count, which would drift the start pulses out of place by the second frame. A format change made in mid-frame is checked for holding the old counts up to the frame wrap: a generator that switched at once would truncate the frame and shift `vst_o`. The parity of `vck_o` and `pol_o` is tracked across frames with an odd line total, so a toggle that resets at the frame boundary is exposed. The end of the black-frame interval relative to `vst_o` is compared cycle by cycle.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int unsigned NUM_FMT = 5;

    typedef enum logic [2:0] {
        FMT_W832 = 3'd0,
        FMT_W800 = 3'd1,
        FMT_W762 = 3'd2,
        FMT_W640T = 3'd3,
        FMT_W640S = 3'd4
    } fmt_e;

    // Registered drive bundle toward the panel pins
    typedef struct packed {
        logic hck1;
        logic hck2;
        logic hst;
        logic vst;
        logic vck;
        logic enb;
        logic blk;
        logic pcg_any;
        logic pol;
    } drive_t;

    // Unused codes alias the largest format
    function automatic fmt_e fmt_decode(input logic [2:0] code);
        if (code > 3'd4)
            return FMT_W832;
        return fmt_e'(code);
    endfunction

    function automatic int unsigned tab_max(input int unsigned t [NUM_FMT]);
        int unsigned m;
        m = 0;
        for (int i = 0; i < NUM_FMT; i++)
            if (t[i] > m)
                m = t[i];
        return m;
    endfunction

endpackage

// File: rtl/lcd_scan_fmt_ctl.sv
module lcd_scan_fmt_ctl
    import lcd_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       frame_end,
    output fmt_e       fmt_act
);

    logic [2:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= mode_sel;
            fmt_act <= fmt_decode(mode_sel);
        end else begin
            req_q <= mode_sel;
            if (frame_end)
                fmt_act <= fmt_decode(req_q);
        end
    end

    // R8: the applied format only moves on the frame wrap
    p_fmt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(fmt_act));

endmodule

// File: rtl/lcd_scan_hcnt.sv
module lcd_scan_hcnt #(
    parameter int unsigned HCK_HALF = 3,
    parameter int unsigned CW       = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CW-1:0]                 nt,
    output logic [$clog2(2*HCK_HALF)-1:0] ph_q,
    output logic [CW-1:0]                 col_q,
    output logic                          line_end
);

    localparam int unsigned PW = $clog2(2*HCK_HALF);
    localparam logic [PW-1:0] PH_LAST = PW'(2*HCK_HALF - 1);

    logic ph_last;

    always_comb begin
        ph_last  = (ph_q == PH_LAST);
        line_end = ph_last && (col_q == nt - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            col_q <= '0;
        end else if (ph_last) begin
            ph_q  <= '0;
            col_q <= line_end ? '0 : col_q + CW'(1);
        end else begin
            ph_q <= ph_q + PW'(1);
        end
    end

    // R1: the column index stays inside the selected line length
    p_col_range_r1: assert property (@(posedge clk) disable iff (rst)
        col_q < nt);

endmodule

// File: rtl/lcd_scan_vcnt.sv
module lcd_scan_vcnt #(
    parameter int unsigned VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic [VW-1:0] vt,
    output logic [VW-1:0] row_q,
    output logic          frame_end
);

    assign frame_end = line_end && (row_q == vt - VW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (line_end)
            row_q <= frame_end ? '0 : row_q + VW'(1);
    end

    // R1: the row index stays inside the selected frame length
    p_row_range_r1: assert property (@(posedge clk) disable iff (rst)
        row_q < vt);

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int unsigned LINES_TAB [NUM_FMT] = '{624, 600, 572, 480, 400},
    parameter int unsigned HCKS_TAB  [NUM_FMT] = '{140, 134, 128, 108, 108},
    parameter int unsigned HCK_HALF  = 3,
    parameter int unsigned H_BLANK   = 4,
    parameter int unsigned V_BLANK   = 4,
    parameter int unsigned ENB_DLY   = 1,
    parameter int unsigned ENB_W     = 2,
    parameter int unsigned PCG_W     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       dir_h_in,
    input  logic       dir_v_in,
    output logic       hst_o,
    output logic       hck1_o,
    output logic       hck2_o,
    output logic       vst_o,
    output logic       vck_o,
    output logic       enb_o,
    output logic       pcg_o,
    output logic       pol_o,
    output logic [2:0] mode_o,
    output logic       dir_h_o,
    output logic       dir_v_o
);

    localparam int unsigned PW = $clog2(2*HCK_HALF);
    localparam int unsigned CW = $clog2(tab_max(HCKS_TAB) + H_BLANK + 1);
    localparam int unsigned VW = $clog2(tab_max(LINES_TAB) + V_BLANK + 1);

    fmt_e          fmt_act;
    logic [CW-1:0] nt;
    logic [VW-1:0] vt;
    logic [PW-1:0] ph_q;
    logic [CW-1:0] col_q;
    logic [VW-1:0] row_q;
    logic          line_end;
    logic          frame_end;
    drive_t        drv_d, drv_q;
    logic [2:0]    mode_q;

    // Per-format counts from the lookup
    always_comb begin
        nt = CW'(HCKS_TAB[int'(fmt_act)] + H_BLANK);
        vt = VW'(LINES_TAB[int'(fmt_act)] + V_BLANK);
    end

    lcd_scan_fmt_ctl u_fmt (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .frame_end (frame_end),
        .fmt_act   (fmt_act)
    );

    lcd_scan_hcnt #(
        .HCK_HALF (HCK_HALF),
        .CW       (CW)
    ) u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .nt       (nt),
        .ph_q     (ph_q),
        .col_q    (col_q),
        .line_end (line_end)
    );

    lcd_scan_vcnt #(
        .VW (VW)
    ) u_vcnt (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .vt        (vt),
        .row_q     (row_q),
        .frame_end (frame_end)
    );

    // Strobe decode from the position counters
    always_comb begin
        int unsigned pi, ci, ri, nti, vti, nai, vai, mid;
        pi  = 32'(ph_q);
        ci  = 32'(col_q);
        ri  = 32'(row_q);
        nti = 32'(nt);
        vti = 32'(vt);
        nai = HCKS_TAB[int'(fmt_act)];
        vai = LINES_TAB[int'(fmt_act)];
        mid = nti >> 1;

        drv_d.hck1 = (pi < HCK_HALF);
        drv_d.hck2 = !(pi < HCK_HALF);
        drv_d.hst  = ((ci == nti - 1) && (pi >= HCK_HALF)) ||
                     ((ci == 0) && (pi < HCK_HALF));
        drv_d.vst  = (ri == vti - 1);
        drv_d.vck  = drv_q.vck ^ ((pi == 0) && (ci == mid));
        drv_d.pol  = drv_q.pol ^ ((pi == 0) && (ci == 0));
        drv_d.enb  = (ci >= mid + ENB_DLY) && (ci < mid + ENB_DLY + ENB_W);
        drv_d.blk  = (ri >= vai) && (ri < vti - 2);
        drv_d.pcg_any = ((ci >= nai) && (ci < nai + PCG_W)) || drv_d.blk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q      <= '0;
            drv_q.hck2 <= 1'b1;
            mode_q     <= '0;
        end else begin
            drv_q  <= drv_d;
            mode_q <= 3'(fmt_act);
        end
    end

    assign hck1_o  = drv_q.hck1;
    assign hck2_o  = drv_q.hck2;
    assign hst_o   = drv_q.hst;
    assign vst_o   = drv_q.vst;
    assign vck_o   = drv_q.vck;
    assign enb_o   = drv_q.enb;
    assign pcg_o   = drv_q.pcg_any;
    assign pol_o   = drv_q.pol;
    assign mode_o  = mode_q;
    assign dir_h_o = dir_h_in;
    assign dir_v_o = dir_v_in;

    // R3: start pulse ends together with the falling clock phase (hold)
    p_hst_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_q.hst) |-> $fell(drv_q.hck1));

    // R4: the vertical start never rises on a vertical clock edge
    p_vst_vck_apart_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_q.vst) |-> !$changed(drv_q.vck));

    // R5: gate enable is clear when the vertical clock moves
    p_enb_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $changed(drv_q.vck) |-> !drv_q.enb);

    // R6: black frame has ended before the vertical start rises
    p_blk_before_vst_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_q.vst) |-> !$past(drv_q.blk));

    // R7: polarity flips only on a line-start clock rise
    p_pol_line_r7: assert property (@(posedge clk) disable iff (rst)
        $changed(drv_q.pol) |-> $rose(drv_q.hck1));

endmodule

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb_top;

    localparam int HH = 3;
    localparam int HB = 4;
    localparam int VB = 4;
    localparam int ED = 1;
    localparam int EW = 2;
    localparam int PW = 2;

    int tb_lines [5] = '{8, 7, 6, 5, 4};
    int tb_hcks  [5] = '{12, 11, 10, 8, 8};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'd0;
    logic       dir_h_in = 1'b1;
    logic       dir_v_in = 1'b0;
    logic       hst_o, hck1_o, hck2_o, vst_o, vck_o, enb_o, pcg_o, pol_o;
    logic [2:0] mode_o;
    logic       dir_h_o, dir_v_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int n_edges, fbase, lb, cur;

    always #4 clk = ~clk;

    lcd_scan_timing #(
        .LINES_TAB ('{8, 7, 6, 5, 4}),
        .HCKS_TAB  ('{12, 11, 10, 8, 8}),
        .HCK_HALF  (HH),
        .H_BLANK   (HB),
        .V_BLANK   (VB),
        .ENB_DLY   (ED),
        .ENB_W     (EW),
        .PCG_W     (PW)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .dir_h_in (dir_h_in),
        .dir_v_in (dir_v_in),
        .hst_o    (hst_o),
        .hck1_o   (hck1_o),
        .hck2_o   (hck2_o),
        .vst_o    (vst_o),
        .vck_o    (vck_o),
        .enb_o    (enb_o),
        .pcg_o    (pcg_o),
        .pol_o    (pol_o),
        .mode_o   (mode_o),
        .dir_h_o  (dir_h_o),
        .dir_v_o  (dir_v_o)
    );

    task automatic chk(input bit ok, input string req, input int actual, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, actual, expv, $time);
        end
    endtask

    function automatic int dec(input int code);
        return (code > 4) ? 0 : code;
    endfunction

    function automatic int line_len(input int f);
        return (tb_hcks[f] + HB) * 2 * HH;
    endfunction

    function automatic int frame_len(input int f);
        return line_len(f) * (tb_lines[f] + VB);
    endfunction

    task automatic do_reset(input int code);
        @(negedge clk);
        rst = 1'b1;
        mode_sel = 3'(code);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state of every registered output
        chk(hck1_o == 1'b0 && hck2_o == 1'b1, "R10 clock phases in reset", {hck1_o, hck2_o}, 1);
        chk({hst_o, vst_o, vck_o, enb_o, pcg_o, pol_o} == 6'b0, "R10 strobes low in reset",
            {hst_o, vst_o, vck_o, enb_o, pcg_o, pol_o}, 0);
        chk(mode_o == 3'd0, "R10 mode output low in reset", mode_o, 0);
        rst = 1'b0;
        n_edges = 0;
        fbase = 0;
        lb = 0;
        cur = dec(code);
    endtask

    task automatic run(input int k, input int sw_at, input int sw_code);
        for (int i = 0; i < k; i++) begin
            int s, pos, ll, nt, vt, v, q, c, p, mid;
            int e_hst, e_vst, e_vck, e_pol, e_enb, e_pcg, e_h1;
            @(posedge clk);
            @(negedge clk);
            n_edges++;
            s = n_edges - 1;
            while (s - fbase >= frame_len(cur)) begin
                lb += tb_lines[cur] + VB;
                fbase += frame_len(cur);
                cur = dec(int'(mode_sel));
            end
            pos = s - fbase;
            ll  = line_len(cur);
            nt  = tb_hcks[cur] + HB;
            vt  = tb_lines[cur] + VB;
            v   = pos / ll;
            q   = pos % ll;
            c   = q / (2 * HH);
            p   = q % (2 * HH);
            mid = nt / 2;
            e_h1  = (p < HH) ? 1 : 0;
            e_hst = (((c == nt - 1) && (p >= HH)) || ((c == 0) && (p < HH))) ? 1 : 0;
            e_vst = (v == vt - 1) ? 1 : 0;
            e_vck = (lb + v + ((q >= mid * 2 * HH) ? 1 : 0)) % 2;
            e_pol = (lb + v + 1) % 2;
            e_enb = ((c >= mid + ED) && (c < mid + ED + EW)) ? 1 : 0;
            e_pcg = (((c >= tb_hcks[cur]) && (c < tb_hcks[cur] + PW)) ||
                     ((v >= tb_lines[cur]) && (v < vt - 2))) ? 1 : 0;
            chk(int'(mode_o) == cur, "R1 applied format code", mode_o, cur);
            chk(int'(hck1_o) == e_h1, "R2 hck1 phase", hck1_o, e_h1);
            chk(int'(hck2_o) == 1 - e_h1, "R2 hck2 complement", hck2_o, 1 - e_h1);
            chk(int'(hst_o) == e_hst, "R3 horizontal start", hst_o, e_hst);
            chk(int'(vst_o) == e_vst, "R4 vertical start", vst_o, e_vst);
            chk(int'(vck_o) == e_vck, "R4 vertical clock", vck_o, e_vck);
            chk(int'(enb_o) == e_enb, "R5 gate enable", enb_o, e_enb);
            chk(int'(pcg_o) == e_pcg, "R6 precharge/black frame", pcg_o, e_pcg);
            chk(int'(pol_o) == e_pol, "R7 line polarity", pol_o, e_pol);
            // R9: direction levels pass straight through
            dir_h_in = s[3];
            dir_v_in = s[4] ^ s[1];
            #1;
            chk(dir_h_o == dir_h_in && dir_v_o == dir_v_in, "R9 direction passthrough",
                {dir_h_o, dir_v_o}, {dir_h_in, dir_v_in});
            if (s == sw_at)
                mode_sel = 3'(sw_code);
        end
    endtask

    initial begin
        // R1: each format code over a full frame plus margin
        for (int f = 0; f < 5; f++) begin
            do_reset(f);
            run(frame_len(f) + 40, -1, 0);
        end
        // R1: aliased codes fall back to format 0
        for (int f = 5; f < 8; f++) begin
            do_reset(f);
            run(frame_len(0) + 20, -1, 0);
        end
        // R8: mid-frame change to format 4 waits for the frame wrap
        do_reset(0);
        run(frame_len(0) + 2 * frame_len(4) + 30, 300, 4);
        // R8: change back to format 2 mid-frame after a format 3 frame
        do_reset(3);
        run(frame_len(3) + 2 * frame_len(2) + 30, 150, 2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule